// File: doc/BRIEF.md
# RMII Receive Di-bit and Carrier/Data-Valid Generator

This block sits between a receive byte FIFO and the receive side of an RMII link. It takes one byte at a time from a show-ahead FIFO and drives it onto a 2-bit receive data bus, one di-bit per reference-clock tick. A tick is every clock at 100 Mb/s and every tenth clock at 10 Mb/s. It also drives the combined carrier-sense/data-valid output.

The combined output rises the moment the carrier input rises, with no clock in that path. While carrier lasts, the output stays high. After carrier ends, the output goes low on the first di-bit of each pair and high again on the second, for as long as buffered bytes remain. This lets the receiver tell the tail of the frame apart from ongoing carrier. When the carrier input flags a false carrier, the block replaces data with a fixed code for the length of the event.

The carrier and false-carrier inputs are asynchronous. They pass through a two-stage synchroniser before they steer the di-bit sequencing.

Top module: `rmii_rx_gen`

## Requirements
- R1: `crs_dv_o` goes high combinationally when `carrier_i` goes high, before any clock edge.
- R2: While the synchronised carrier is high and not false, `crs_dv_o` is high on every di-bit presented.
- R3: After the synchronised carrier falls, `crs_dv_o` falls only on a tick that presents the first di-bit of a pair (index 0 or 2 of a byte) or idle.
- R4: While draining with carrier low, `crs_dv_o` is low on di-bit indices 0 and 2 and high on indices 1 and 3 of every byte, until the last byte is fully presented.
- R5: While a false carrier is active (both flags high after synchronisation), `rxd_o` is 2'b10 and `crs_dv_o` is high, and no FIFO byte is read.
- R6: With `spd10_i`=0 a new di-bit appears every clock. With `spd10_i`=1 each di-bit is held for exactly 10 clocks.
- R7: A byte is sent least-significant di-bit first: bits [1:0], [3:2], [5:4], then [7:6].
- R8: Once carrier is low and every buffered byte has been presented, `rxd_o` is 2'b00 and `crs_dv_o` is low.
- R9: `fifo_rd_o` pulses for one clock per byte, only when `fifo_empty_i` is low and a new byte is due. The byte on `fifo_data_i` in that cycle is the one presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Asynchronous receive-medium-active indication |
| false_carrier_i | input | 1 | Asynchronous false-carrier flag, valid with carrier |
| spd10_i | input | 1 | 1 selects 10 Mb/s pacing, 0 selects 100 Mb/s |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | 8 | Head byte of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop strobe for the FIFO head |
| rxd_o | output | 2 | Receive di-bit |
| crs_dv_o | output | 1 | Combined carrier-sense / data-valid |

## Verification
A wrong di-bit index shows on `rxd_o` within one tick. It appears as swapped or repeated di-bit pairs, and the byte-order scoreboard catches it on the next comparison. A bad pair-phase bit turns the low/high pattern of `crs_dv_o` during a drain into high/low. A stuck "byte held" flag shows up as extra or missing `fifo_rd_o` pulses, and the FIFO model's read and write pointers then differ at the end. In the 10 Mb/s case, a faulty pace counter makes each di-bit last for something other than ten samples, and the first sample of the following di-bit already fails.

// File: rtl/rmii_rxgen_pkg.sv
package rmii_rxgen_pkg;
  localparam int BYTE_W = 8;
  localparam int DIBITS = BYTE_W / 2;
  localparam int IDX_W  = $clog2(DIBITS);

  typedef logic [IDX_W-1:0]  dibit_idx_t;
  typedef logic [BYTE_W-1:0] rx_byte_t;

  localparam logic [1:0] FC_CODE   = 2'b10;
  localparam logic [1:0] IDLE_CODE = 2'b00;
  localparam dibit_idx_t LAST_IDX  = dibit_idx_t'(DIBITS - 1);

  // di-bit i of a byte, least significant first
  function automatic logic [1:0] dibit_at(rx_byte_t b, dibit_idx_t i);
    return b[{i, 1'b0} +: 2];
  endfunction

  // data-valid level for a presented di-bit: high while carrier, else high on second of pair
  function automatic logic dv_at(logic carrier_s, dibit_idx_t i);
    return carrier_s | i[0];
  endfunction
endpackage

// File: rtl/rmii_rxgen_sync.sv
module rmii_rxgen_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/rmii_rxgen_pace.sv
module rmii_rxgen_pace #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !slow_i) cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !slow_i || (cnt_q == CNT_LAST);

  // R6
  pace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_i |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/rmii_rxgen_ser.sv
module rmii_rxgen_ser
  import rmii_rxgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       carrier_s_i,
  input  logic       fc_i,
  input  logic       empty_i,
  input  rx_byte_t   data_i,
  output logic       rd_o,
  output logic [1:0] rxd_o,
  output logic       dv_o,
  output logic       first_o
);
  rx_byte_t   shreg_q;
  dibit_idx_t idx_q;
  logic       have_q;
  logic       byte_done;
  dibit_idx_t idx_nx;

  assign byte_done = !have_q || (idx_q == LAST_IDX);
  assign idx_nx    = idx_q + 1'b1;
  assign rd_o      = tick_i && !fc_i && byte_done && !empty_i;
  assign first_o   = !have_q || !idx_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
      have_q  <= 1'b0;
      rxd_o   <= IDLE_CODE;
      dv_o    <= 1'b0;
    end else if (tick_i) begin
      if (fc_i) begin
        rxd_o <= FC_CODE;
        dv_o  <= 1'b1;
      end else if (!byte_done) begin
        idx_q <= idx_nx;
        rxd_o <= dibit_at(shreg_q, idx_nx);
        dv_o  <= dv_at(carrier_s_i, idx_nx);
      end else if (!empty_i) begin
        shreg_q <= data_i;
        idx_q   <= '0;
        have_q  <= 1'b1;
        rxd_o   <= dibit_at(data_i, '0);
        dv_o    <= dv_at(carrier_s_i, '0);
      end else begin
        have_q <= 1'b0;
        idx_q  <= '0;
        rxd_o  <= IDLE_CODE;
        dv_o   <= carrier_s_i;
      end
    end
  end

  // R9
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> !empty_i);

  // R3
  dv_fall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_o) |-> first_o);

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !fc_i && byte_done && empty_i && !carrier_s_i) |=> (rxd_o == IDLE_CODE && !dv_o));

  // R9
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> (rxd_o == $past(data_i[1:0]) && first_o));
endmodule

// File: rtl/rmii_rx_gen.sv
module rmii_rx_gen
  import rmii_rxgen_pkg::*;
#(
  parameter int SLOW_DIV    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_i,
  input  logic              false_carrier_i,
  input  logic              spd10_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic [1:0]        rxd_o,
  output logic              crs_dv_o
);
  logic [1:0] flags_s;
  logic       carrier_s;
  logic       fc_active;
  logic       tick_w;
  logic       dv_q;
  logic       first_w;

  rmii_rxgen_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({false_carrier_i, carrier_i}),
    .q_o   (flags_s)
  );

  assign carrier_s = flags_s[0];
  assign fc_active = flags_s[1] && flags_s[0];

  rmii_rxgen_pace #(.DIV(SLOW_DIV)) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .slow_i (spd10_i),
    .tick_o (tick_w)
  );

  rmii_rxgen_ser u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_w),
    .carrier_s_i (carrier_s),
    .fc_i        (fc_active),
    .empty_i     (fifo_empty_i),
    .data_i      (fifo_data_i),
    .rd_o        (fifo_rd_o),
    .rxd_o       (rxd_o),
    .dv_o        (dv_q),
    .first_o     (first_w)
  );

  // asynchronous rise path: raw carrier bypasses the synchroniser
  assign crs_dv_o = carrier_i | dv_q;

  // R6
  rxd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w |=> $stable(rxd_o));

  // R5
  fc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_active && tick_w) |=> (rxd_o == FC_CODE && crs_dv_o));

  // R5
  fc_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_active |-> !fifo_rd_o);

  // R2
  carrier_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_s && tick_w) |=> dv_q);
endmodule

// File: tb/tb_rmii_rx_gen.sv
`timescale 1ns/1ps
module tb_rmii_rx_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier = 1'b0;
  logic       fc = 1'b0;
  logic       spd10 = 1'b0;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_rd;
  logic [1:0] rxd;
  logic       crs_dv;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // FIFO model
  logic [7:0] mem [64];
  int wp = 0;
  int rp = 0;
  assign fifo_empty = (wp == rp);
  assign fifo_data  = mem[rp % 64];
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  rmii_rx_gen dut (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .false_carrier_i(fc),
    .spd10_i(spd10), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_rd_o(fifo_rd), .rxd_o(rxd), .crs_dv_o(crs_dv)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard item: {dv_care, dv, dibit[1:0]}
  logic [3:0] expq [$];

  // driver: byte into FIFO model, four expected di-bits, R7 order (LSB first)
  task automatic push_byte(input logic [7:0] b, input bit drain);
    mem[wp % 64] = b;
    wp = wp + 1;
    for (int i = 0; i < 4; i++) begin
      logic dv_e;
      dv_e = drain ? logic'(i % 2) : 1'b1;
      expq.push_back({1'b1, dv_e, b[2*i +: 2]});
    end
  endtask

  // monitor
  int mon_cnt = 0;
  bit mon_act = 0;
  logic [3:0] cur;
  always @(negedge clk) begin
    int hold;
    hold = spd10 ? 10 : 1;
    if (rst_n) begin
      // R9: pop only with data
      if (fifo_rd) check(!fifo_empty, "R9 read while empty", 1, 0);
      if (mon_act) begin
        if (mon_cnt % hold == 0) begin
          if (expq.size() == 0) begin
            check(1'b0, "R9 unexpected di-bit", rxd, 0);
            cur = 4'b0;
          end else cur = expq.pop_front();
        end
        // R6 hold length, R7 order
        check(rxd == cur[1:0], "R7/R6 di-bit", rxd, cur[1:0]);
        // R2 / R4 data-valid pattern
        if (cur[3]) check(crs_dv == cur[2], "R2/R4 crs_dv", crs_dv, cur[2]);
        mon_cnt++;
        if (mon_cnt >= 4 * hold) mon_act = 0;
      end
      if (fifo_rd) begin
        mon_act = 1;
        mon_cnt = 0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state, R8
    check(rxd == 2'b00, "R8 reset rxd", rxd, 0);
    check(crs_dv == 1'b0, "R8 reset crs_dv", crs_dv, 0);
    check(fifo_rd == 1'b0, "R9 reset rd", fifo_rd, 0);

    // R1: asynchronous rise, checked between edges
    #1 carrier = 1'b1;
    #1 check(crs_dv == 1'b1, "R1 async rise", crs_dv, 1);
    cyc(5);

    // R2: 100 Mb/s frame under carrier
    push_byte(8'hA5, 0);
    push_byte(8'h1E, 0);
    push_byte(8'hC3, 0);
    cyc(20);
    check(expq.size() == 0, "R9 all bytes read", expq.size(), 0);
    carrier = 1'b0;
    cyc(6);
    // R8: idle after carrier drop with empty FIFO
    check(rxd == 2'b00 && crs_dv == 1'b0, "R8 idle 100", {crs_dv, rxd}, 0);

    // R4: drain at 100 Mb/s with carrier low
    push_byte(8'h6C, 1);
    push_byte(8'hF0, 1);
    push_byte(8'h39, 1);
    cyc(20);
    check(expq.size() == 0, "R4 drain consumed", expq.size(), 0);
    check(rxd == 2'b00 && crs_dv == 1'b0, "R8 idle after drain", {crs_dv, rxd}, 0);

    // R6: 10 Mb/s drain and carrier frame
    spd10 = 1'b1;
    cyc(12);
    push_byte(8'hD2, 1);
    push_byte(8'h4B, 1);
    cyc(100);
    check(expq.size() == 0, "R6 slow drain consumed", expq.size(), 0);
    carrier = 1'b1;
    cyc(5);
    push_byte(8'h87, 0);
    cyc(60);
    carrier = 1'b0;
    cyc(30);
    check(rxd == 2'b00 && crs_dv == 1'b0, "R8 idle 10", {crs_dv, rxd}, 0);

    // R5: false carrier at 100 Mb/s
    spd10 = 1'b0;
    cyc(3);
    carrier = 1'b1;
    fc = 1'b1;
    cyc(5);
    for (int i = 0; i < 12; i++) begin
      check(rxd == 2'b10, "R5 fc code", rxd, 2);
      check(crs_dv == 1'b1, "R5 fc crs_dv", crs_dv, 1);
      cyc(1);
    end
    carrier = 1'b0;
    fc = 1'b0;
    cyc(6);
    check(rxd == 2'b00 && crs_dv == 1'b0, "R8 idle after fc", {crs_dv, rxd}, 0);
    check(rp == wp, "R9 pointer match", rp, wp);
    check(expq.size() == 0, "R9 scoreboard empty", expq.size(), 0);
    finish_run();
  end
endmodule